// File: doc/BRIEF.md
# Comparison Reference Generator with Regional Rate Routing

This block turns a gated crystal oscillator into the comparison strobes used by two phase-locked loops, one for the transmitter and one for the receiver. A programmable 12-bit ratio divides the enabled oscillator cycles down to a base strobe. Two fixed post-dividers run off that base strobe: one produces a strobe every 4 base strobes and the other every 25. A 2-bit region code chooses which of the three rates drives the transmit strobe and which drives the receive strobe. The two choices are made independently.

Software writes the ratio and the region code as plain inputs. A new ratio is held off until the running period wraps, so a write never shortens a period in progress. A third output shows the second-stage strobe, which is what a tester probes to check the post-divider chain.

Top module: `cmpref_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first base wrap, all three outputs are low. After reset the active ratio is 2048, and both post-dividers start from zero.
- R2: The base strobe fires once every N enabled oscillator cycles, where N is the active ratio. The first base strobe after reset follows the 2048th enabled cycle.
- R3: Every output strobe is high for exactly one clock cycle.
- R4: The quarter rate fires once every 4 base strobes and the slow rate once every 25 base strobes. Each fires one clock after the base strobe that completes its cycle.
- R5: The routing for region_sel[1:0] is as follows. 00 sends the base rate to both TX and RX. 01 sends the quarter rate to both. 10 sends the quarter rate to TX and the slow rate to RX. 11 sends the slow rate to TX and the quarter rate to RX.
- R6: test_tick stays low for region_sel 00. It carries the quarter rate for 01 and the slow rate for 10 and 11.
- R7: A ratio value below 16, including 0, acts as 16.
- R8: A changed ratio is taken at the next base wrap. The period already running completes with the old ratio.
- R9: A clock cycle with osc_en low does not advance the base count.
- R10: The largest ratio, 4095, gives a base period of 4095 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_en | input | 1 | Oscillator cycle enable; one count per high cycle |
| div_cfg | input | 12 | Requested base ratio |
| region_sel | input | 2 | Region code choosing the TX and RX rates |
| tx_ref_tick | output | 1 | Transmit comparison strobe |
| rx_ref_tick | output | 1 | Receive comparison strobe |
| test_tick | output | 1 | Second-stage strobe for test observation |

## Verification
A wrong base count shows up as a pulse spacing that is not the programmed ratio. The error is visible at the first wrap, at most 4095 enabled cycles after the fault. A post-divider that is off by one shifts the quarter or slow strobe spacing by one base period, so a single gap measurement at a small ratio exposes it within a few hundred cycles. A routing mistake in the region table gives TX and RX spacings that differ from the expected pair for that region code. A ratio latched at the wrong moment produces one gap of the wrong length right after a write.

// File: rtl/cmpref_pkg.sv
package cmpref_pkg;

  typedef enum logic [1:0] {
    RATE_BASE = 2'd0,
    RATE_Q4   = 2'd1,
    RATE_Q25  = 2'd2
  } rate_e;

  function automatic logic rate_pick(rate_e r, logic base_t, logic q4_t, logic q25_t);
    case (r)
      RATE_Q4:  rate_pick = q4_t;
      RATE_Q25: rate_pick = q25_t;
      default:  rate_pick = base_t;
    endcase
  endfunction

endpackage

// File: rtl/cmpref_base_div.sv
module cmpref_base_div #(
  parameter int DIV_W   = 12,
  parameter int MIN_DIV = 16,
  parameter int RST_DIV = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] START = DIV_W'(RST_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] prd_q, prd_d;
  logic [DIV_W-1:0] eff;
  logic             tick_q, tick_d;

  always_comb begin
    eff    = (div_cfg < FLOOR) ? FLOOR : div_cfg;
    cnt_d  = cnt_q;
    prd_d  = prd_q;
    tick_d = 1'b0;
    if (en) begin
      if (cnt_q == prd_q - 1'b1) begin
        cnt_d  = '0;
        prd_d  = eff;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prd_q  <= START;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prd_q  <= prd_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r3_base_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  a_r7_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_q >= FLOOR) && (cnt_q < prd_q));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt_q) && !tick_q));

  a_r8_ratio_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_q != $past(prd_q)) |-> tick_q);

endmodule

// File: rtl/cmpref_sub_div.sv
module cmpref_sub_div #(
  parameter int MOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_i,
  output logic tick_o
);

  localparam int CW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (base_i) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  a_r4_follows_base: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(base_i));

  a_r3_sub_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

endmodule

// File: rtl/cmpref_route.sv
module cmpref_route
  import cmpref_pkg::*;
(
  input  logic       base_i,
  input  logic       q4_i,
  input  logic       q25_i,
  input  logic [1:0] sel_i,
  output logic       tx_o,
  output logic       rx_o,
  output logic       aux_o
);

  rate_e tx_src, rx_src;

  always_comb begin
    case (sel_i)
      2'b01:   begin tx_src = RATE_Q4;   rx_src = RATE_Q4;   end
      2'b10:   begin tx_src = RATE_Q4;   rx_src = RATE_Q25;  end
      2'b11:   begin tx_src = RATE_Q25;  rx_src = RATE_Q4;   end
      default: begin tx_src = RATE_BASE; rx_src = RATE_BASE; end
    endcase
    tx_o = rate_pick(tx_src, base_i, q4_i, q25_i);
    rx_o = rate_pick(rx_src, base_i, q4_i, q25_i);
    case (sel_i)
      2'b00:   aux_o = 1'b0;
      2'b01:   aux_o = q4_i;
      default: aux_o = q25_i;
    endcase
  end

endmodule

// File: rtl/cmpref_gen.sv
module cmpref_gen #(
  parameter int DIV_W   = 12,
  parameter int MIN_DIV = 16,
  parameter int RST_DIV = 2048,
  parameter int Q_MID   = 4,
  parameter int Q_SLOW  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [1:0]       region_sel,
  output logic             tx_ref_tick,
  output logic             rx_ref_tick,
  output logic             test_tick
);

  localparam int NSUB = 2;

  logic [1:0]      rsync_q;
  logic            rst_int_n;
  logic            base_tick;
  logic [NSUB-1:0] sub_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  cmpref_base_div #(
    .DIV_W  (DIV_W),
    .MIN_DIV(MIN_DIV),
    .RST_DIV(RST_DIV)
  ) u_base (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en     (osc_en),
    .div_cfg(div_cfg),
    .tick_o (base_tick)
  );

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    cmpref_sub_div #(
      .MOD((g == 0) ? Q_MID : Q_SLOW)
    ) u_sub (
      .clk   (clk),
      .rst_n (rst_int_n),
      .base_i(base_tick),
      .tick_o(sub_tick[g])
    );
  end

  cmpref_route u_route (
    .base_i(base_tick),
    .q4_i  (sub_tick[0]),
    .q25_i (sub_tick[1]),
    .sel_i (region_sel),
    .tx_o  (tx_ref_tick),
    .rx_o  (rx_ref_tick),
    .aux_o (test_tick)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!tx_ref_tick && !rx_ref_tick && !test_tick));

  a_r5_shared_rate: assert property (@(posedge clk) disable iff (!rst_int_n)
    (region_sel[1] == 1'b0) |-> (tx_ref_tick == rx_ref_tick));

  a_r6_test_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (region_sel == 2'b00) |-> !test_tick);

  a_r3_tx_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_ref_tick |=> (!tx_ref_tick || (region_sel != $past(region_sel))));

endmodule

// File: tb/sim_cmpref_gen.sv
module sim_cmpref_gen;

  logic        clk;
  logic        rst_n;
  logic        en_req;
  logic        gate_mode;
  logic        phase;
  logic        osc_en;
  logic [11:0] div_cfg;
  logic [1:0]  region_sel;
  logic        tx_ref_tick, rx_ref_tick, test_tick;

  int cyc;
  int total;
  int bad;
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) phase <= ~phase;
  assign osc_en = en_req & (~gate_mode | phase);

  cmpref_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .div_cfg    (div_cfg),
    .region_sel (region_sel),
    .tx_ref_tick(tx_ref_tick),
    .rx_ref_tick(rx_ref_tick),
    .test_tick  (test_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic probe(input int which);
    case (which)
      0:       probe = tx_ref_tick;
      1:       probe = rx_ref_tick;
      default: probe = test_tick;
    endcase
  endfunction

  task automatic wait_pulse(input int which, output int at);
    at = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (probe(which)) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic gap(input int which, output int g);
    int t1, t2;
    wait_pulse(which, t1);
    wait_pulse(which, t2);
    g = (t1 < 0 || t2 < 0) ? -1 : t2 - t1;
  endtask

  task automatic do_reset();
    en_req = 1'b0;
    rst_n  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1 R2 R3: quiet outputs through reset, first wrap after 2048 enabled cycles
  task automatic t_first_wrap();
    int c0, t, hi;
    div_cfg = 12'd16; region_sel = 2'b00; gate_mode = 1'b0;
    do_reset();
    hi = 0;
    repeat (5) begin
      @(negedge clk);
      hi += int'(tx_ref_tick) + int'(rx_ref_tick) + int'(test_tick);
    end
    chk("R1 outputs low after reset", hi, 0);
    en_req = 1'b1; c0 = cyc;
    wait_pulse(0, t);
    chk("R2 first base wrap", t - c0, 2048);
    @(negedge clk);
    chk("R3 tx strobe one cycle", int'(tx_ref_tick), 0);
    gap(0, t);
    chk("R2 base period 16", t, 16);
  endtask

  // R1 R4: post-dividers start from zero after reset
  task automatic t_sub_start();
    int c0, t;
    div_cfg = 12'd16; region_sel = 2'b01;
    do_reset();
    repeat (3) @(negedge clk);
    en_req = 1'b1; c0 = cyc;
    wait_pulse(0, t);
    chk("R1 R4 first quarter strobe", t - c0, 2048 + 48 + 1);
  endtask

  // R5 R6 R4: each region code
  task automatic t_regions();
    int g, n;
    div_cfg = 12'd16;
    region_sel = 2'b00;
    n = 0;
    repeat (500) begin
      @(negedge clk);
      n += int'(test_tick);
    end
    chk("R6 test idle for 00", n, 0);
    gap(1, g); chk("R5 rx base for 00", g, 16);
    region_sel = 2'b01;
    gap(0, g); chk("R5 R4 tx quarter for 01", g, 64);
    gap(1, g); chk("R5 rx quarter for 01", g, 64);
    gap(2, g); chk("R6 test quarter for 01", g, 64);
    region_sel = 2'b10;
    gap(0, g); chk("R5 tx quarter for 10", g, 64);
    gap(1, g); chk("R5 R4 rx slow for 10", g, 400);
    gap(2, g); chk("R6 test slow for 10", g, 400);
    region_sel = 2'b11;
    gap(0, g); chk("R5 tx slow for 11", g, 400);
    gap(1, g); chk("R5 rx quarter for 11", g, 64);
    gap(2, g); chk("R6 test slow for 11", g, 400);
    wait_pulse(0, g);
    @(negedge clk);
    chk("R3 slow strobe one cycle", int'(tx_ref_tick), 0);
  endtask

  // R8: ratio change waits for the next wrap
  task automatic t_ratio_change();
    int t0, t1, t2;
    region_sel = 2'b00; div_cfg = 12'd16;
    wait_pulse(0, t0);
    wait_pulse(0, t0);
    div_cfg = 12'd40;
    wait_pulse(0, t1);
    wait_pulse(0, t2);
    chk("R8 running period keeps old ratio", t1 - t0, 16);
    chk("R8 new ratio after wrap", t2 - t1, 40);
  endtask

  // R7 R10: clamp and maximum
  task automatic t_limits();
    int t, g;
    region_sel = 2'b00;
    div_cfg = 12'd0;
    wait_pulse(0, t);
    gap(0, g); chk("R7 zero ratio clamps to 16", g, 16);
    div_cfg = 12'd5;
    wait_pulse(0, t);
    gap(0, g); chk("R7 ratio 5 clamps to 16", g, 16);
    div_cfg = 12'd4095;
    wait_pulse(0, t);
    gap(0, g); chk("R10 max ratio period", g, 4095);
  endtask

  // R9: idle enable cycles do not count
  task automatic t_gated();
    int t, g;
    region_sel = 2'b00; div_cfg = 12'd16;
    wait_pulse(0, t);
    gate_mode = 1'b1;
    wait_pulse(0, t);
    gap(0, g); chk("R9 half-rate enable doubles period", g, 32);
    gate_mode = 1'b0;
  endtask

  initial begin
    cyc = 0; total = 0; bad = 0; done = 1'b0;
    phase = 1'b0; gate_mode = 1'b0; en_req = 1'b0;
    div_cfg = 12'd16; region_sel = 2'b00; rst_n = 1'b0;
    t_first_wrap();
    t_sub_start();
    t_regions();
    t_ratio_change();
    t_limits();
    t_gated();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule